// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor in which instructions and data share one memory. Every instruction passes through a visible register-transfer sequence: the program counter is copied into the memory address register, the addressed word is read into the memory data register while the program counter steps forward, and that word is then moved into the current instruction register. A decode state splits the instruction into its opcode and its operand address. Execute states then work on a single 16-bit accumulator.

The memory port is synchronous. A read strobe samples the address at a clock edge, and the returned word is captured one cycle later. A write strobe stores the write data at the address. Word input uses a valid/ready handshake, and the core stalls until a word is offered. Word output is a single-cycle valid pulse with the accumulator on the data lines. After a halt, the core holds a halted flag and leaves the memory untouched.

Controller states and transitions:
- Fetch runs FETCH_ADDR → FETCH_READ → FETCH_MDR → FETCH_CIR → DECODE.
- Memory-operand instructions run DECODE → OPND_ADDR → OPND_READ → OPND_MDR → ACC_UPDATE → FETCH_ADDR.
- Store runs DECODE → STORE_ADDR → STORE_WRITE → FETCH_ADDR.
- Branches run DECODE → BRANCH → FETCH_ADDR.
- Input runs DECODE → INPUT, which loops on itself until a word is offered, then → FETCH_ADDR.
- Output runs DECODE → OUTPUT → FETCH_ADDR.
- Halt and undefined opcodes run DECODE → HALT, which loops on itself.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, every strobe, in_ready, out_valid and halted are low and out_data is zero. After reset, the first memory read is at address 0, one cycle after the first clock edge.
- R2: Fetch reads the word at the program counter address, steps the program counter by one in that same cycle, and moves the fetched word into the instruction register. Consecutive instructions therefore run in address order.
- R3: An instruction word carries the opcode in bits 15:12 and the operand address in bits 7:0. The opcodes are: 0 halt, 1 add, 2 subtract, 3 store, 5 load, 6 branch always, 7 branch on zero, 8 branch on non-negative, 9 input, 10 output. Any other opcode behaves as halt.
- R4: Add and subtract read the operand word and put the wrapped 16-bit two's complement sum or difference into the accumulator.
- R5: Load puts the operand word into the accumulator. Store writes the accumulator to the operand address with mem_wr high for exactly one cycle, and mem_rd low in that cycle.
- R6: Branch always continues execution at the operand address.
- R7: Branch on zero continues at the operand address only when the accumulator is zero. Otherwise it falls through.
- R8: Branch on non-negative continues at the operand address when accumulator bit 15 is clear, and zero counts as taken. A negative accumulator falls through.
- R9: Input holds in_ready high and issues no memory access until in_valid is high. It then loads in_data into the accumulator.
- R10: Output raises out_valid for exactly one cycle, with out_data equal to the accumulator.
- R11: After halt, halted stays high and no further memory read, memory write or output pulse occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Memory address, driven by the address register |
| mem_wdata | output | 16 | Memory write data, driven by the data register |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 16 | Registered read data from memory |
| in_valid | input | 1 | Input word offered |
| in_data | input | 16 | Input word |
| in_ready | output | 1 | Core waits for an input word |
| out_valid | output | 1 | One-cycle output pulse |
| out_data | output | 16 | Accumulator value |
| halted | output | 1 | Core has stopped |

## Verification
A fault in the controller state or in the instruction register shows up as a missing, extra or misplaced memory strobe. It appears within a few cycles of decode, and at the latest at the next store or output. A corrupt accumulator or program counter shows up on the next output pulse or store as a wrong value or address, or as a skipped or extra output along the branch path. A halt state that is left shows up as a read strobe within one cycle. A missed wait in the input state shows up as memory activity while in_ready is high.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT   = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADD    = 4'd1;
    localparam logic [OPC_W-1:0] OPC_SUB    = 4'd2;
    localparam logic [OPC_W-1:0] OPC_STORE  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'd6;
    localparam logic [OPC_W-1:0] OPC_JZERO  = 4'd7;
    localparam logic [OPC_W-1:0] OPC_JNNEG  = 4'd8;
    localparam logic [OPC_W-1:0] OPC_INPUT  = 4'd9;
    localparam logic [OPC_W-1:0] OPC_OUTPUT = 4'd10;

    typedef enum logic [3:0] {
        S_FETCH_ADDR,
        S_FETCH_READ,
        S_FETCH_MDR,
        S_FETCH_CIR,
        S_DECODE,
        S_OPND_ADDR,
        S_OPND_READ,
        S_OPND_MDR,
        S_ACC_UPDATE,
        S_STORE_ADDR,
        S_STORE_WRITE,
        S_BRANCH,
        S_INPUT,
        S_OUTPUT,
        S_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        ACC_HOLD,
        ACC_ADD,
        ACC_SUB,
        ACC_LOAD,
        ACC_IN
    } acc_op_e;

    typedef struct packed {
        logic    mar_ld;
        logic    mar_opnd;
        logic    pc_inc;
        logic    pc_ld;
        logic    mdr_ld;
        logic    mdr_acc;
        logic    cir_ld;
        acc_op_e acc_op;
        logic    mem_rd;
        logic    mem_wr;
    } dp_ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] ext_val,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        unique case (op)
            ACC_ADD:  result = acc_val + mem_val;
            ACC_SUB:  result = acc_val - mem_val;
            ACC_LOAD: result = mem_val;
            ACC_IN:   result = ext_val;
            default:  result = acc_val;
        endcase
    end

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctrl_t          ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mdr,
    output logic [DATA_W-1:0] acc,
    output logic [OPC_W-1:0]  cir_op,
    output logic              acc_zero,
    output logic              acc_neg
);

    localparam int OP_LSB = DATA_W - OPC_W;

    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] cir_opnd;
    logic [DATA_W-1:0] alu_y;

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (ctl.acc_op),
        .acc_val (acc),
        .mem_val (mdr),
        .ext_val (in_data),
        .result  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            mar      <= '0;
            mdr      <= '0;
            cir_op   <= '0;
            cir_opnd <= '0;
            acc      <= '0;
        end else begin
            if (ctl.pc_ld) begin
                pc <= cir_opnd;
            end else if (ctl.pc_inc) begin
                pc <= pc + 1'b1;
            end
            if (ctl.mar_ld) begin
                mar <= ctl.mar_opnd ? cir_opnd : pc;
            end
            if (ctl.mdr_ld) begin
                mdr <= ctl.mdr_acc ? acc : mem_rdata;
            end
            if (ctl.cir_ld) begin
                cir_op   <= mdr[DATA_W-1:OP_LSB];
                cir_opnd <= mdr[ADDR_W-1:0];
            end
            if (ctl.acc_op != ACC_HOLD) begin
                acc <= alu_y;
            end
        end
    end

    assign acc_zero = (acc == '0);
    assign acc_neg  = acc[DATA_W-1];

    // R2: program counter steps by one on the fetch read
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pc_inc && !ctl.pc_ld) |=> (pc == $past(pc) + 1'b1));

    // R2: instruction register takes the fetched word
    a_r2_cir_copy: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.cir_ld |=> (cir_op == $past(mdr[DATA_W-1:OP_LSB])));

    // R6: a taken branch lands on the operand
    a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.pc_ld |=> (pc == $past(cir_opnd)));

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] cir_op,
    input  logic             acc_zero,
    input  logic             acc_neg,
    input  logic             in_valid,
    output dp_ctrl_t         ctl,
    output logic             in_ready,
    output logic             out_valid,
    output logic             halted
);

    cpu_state_e state, state_nx;
    logic       take_branch;

    always_comb begin
        take_branch = (cir_op == OPC_JUMP)
                   || ((cir_op == OPC_JZERO) && acc_zero)
                   || ((cir_op == OPC_JNNEG) && !acc_neg);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH_ADDR;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH_ADDR:  state_nx = S_FETCH_READ;
            S_FETCH_READ:  state_nx = S_FETCH_MDR;
            S_FETCH_MDR:   state_nx = S_FETCH_CIR;
            S_FETCH_CIR:   state_nx = S_DECODE;
            S_DECODE: begin
                unique case (cir_op)
                    OPC_ADD, OPC_SUB, OPC_LOAD:     state_nx = S_OPND_ADDR;
                    OPC_STORE:                      state_nx = S_STORE_ADDR;
                    OPC_JUMP, OPC_JZERO, OPC_JNNEG: state_nx = S_BRANCH;
                    OPC_INPUT:                      state_nx = S_INPUT;
                    OPC_OUTPUT:                     state_nx = S_OUTPUT;
                    default:                        state_nx = S_HALT;
                endcase
            end
            S_OPND_ADDR:   state_nx = S_OPND_READ;
            S_OPND_READ:   state_nx = S_OPND_MDR;
            S_OPND_MDR:    state_nx = S_ACC_UPDATE;
            S_ACC_UPDATE:  state_nx = S_FETCH_ADDR;
            S_STORE_ADDR:  state_nx = S_STORE_WRITE;
            S_STORE_WRITE: state_nx = S_FETCH_ADDR;
            S_BRANCH:      state_nx = S_FETCH_ADDR;
            S_INPUT:       state_nx = in_valid ? S_FETCH_ADDR : S_INPUT;
            S_OUTPUT:      state_nx = S_FETCH_ADDR;
            S_HALT:        state_nx = S_HALT;
            default:       state_nx = S_HALT;
        endcase
    end

    always_comb begin
        ctl       = '0;
        ctl.acc_op = ACC_HOLD;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        halted    = 1'b0;
        unique case (state)
            S_FETCH_ADDR: ctl.mar_ld = 1'b1;
            S_FETCH_READ: begin
                ctl.mem_rd = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            S_FETCH_MDR:  ctl.mdr_ld = 1'b1;
            S_FETCH_CIR:  ctl.cir_ld = 1'b1;
            S_DECODE:     ;
            S_OPND_ADDR: begin
                ctl.mar_ld   = 1'b1;
                ctl.mar_opnd = 1'b1;
            end
            S_OPND_READ:  ctl.mem_rd = 1'b1;
            S_OPND_MDR:   ctl.mdr_ld = 1'b1;
            S_ACC_UPDATE: begin
                if (cir_op == OPC_ADD) begin
                    ctl.acc_op = ACC_ADD;
                end else if (cir_op == OPC_SUB) begin
                    ctl.acc_op = ACC_SUB;
                end else begin
                    ctl.acc_op = ACC_LOAD;
                end
            end
            S_STORE_ADDR: begin
                ctl.mar_ld   = 1'b1;
                ctl.mar_opnd = 1'b1;
                ctl.mdr_ld   = 1'b1;
                ctl.mdr_acc  = 1'b1;
            end
            S_STORE_WRITE: ctl.mem_wr = 1'b1;
            S_BRANCH:      ctl.pc_ld = take_branch;
            S_INPUT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    ctl.acc_op = ACC_IN;
                end
            end
            S_OUTPUT:      out_valid = 1'b1;
            S_HALT:        halted = 1'b1;
            default:       halted = 1'b1;
        endcase
    end

    // R5: the write strobe lasts one cycle
    a_r5_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_wr |=> !ctl.mem_wr);

    // R5: never read and write together
    a_r5_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.mem_rd && ctl.mem_wr));

    // R10: the output strobe lasts one cycle
    a_r10_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R9: the input state holds until a word is offered
    a_r9_inp_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

    // R11: halted never drops before reset
    a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11: no memory traffic once halted
    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!ctl.mem_rd && !ctl.mem_wr && !out_valid));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted
);

    dp_ctrl_t          ctl;
    logic [OPC_W-1:0]  cir_op;
    logic              acc_zero;
    logic              acc_neg;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mdr;
    logic [DATA_W-1:0] acc;

    acc_cpu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cir_op    (cir_op),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg),
        .in_valid  (in_valid),
        .ctl       (ctl),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .halted    (halted)
    );

    acc_cpu_datapath #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .in_data   (in_data),
        .mar       (mar),
        .mdr       (mdr),
        .acc       (acc),
        .cir_op    (cir_op),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign out_data  = acc;

    // R5: a store puts the accumulator on the write lines
    a_r5_store_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == acc));

endmodule

// File: tb/tb_acc_cpu_core.sv
module tb_acc_cpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_rdata;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, halted;
    logic [15:0] out_data;

    logic [15:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int idle_hits = 0;
    bit idle_watch = 1'b0;
    bit finished = 1'b0;

    logic [15:0] exp_out[$];
    string       exp_out_tag[$];
    logic [7:0]  exp_wa[$];
    logic [15:0] exp_wd[$];

    always #10 clk = ~clk;

    acc_cpu_core dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [7:0] a);
        return {op, 4'h0, a};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) put(i[7:0], 16'h0);
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(halted, tag, {15'b0, halted}, 16'h1);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_out.size() == 0) begin
                    check(1'b0, "R10 unexpected output", out_data, 16'h0);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_out.pop_front();
                    t = exp_out_tag.pop_front();
                    check(out_data == e, t, out_data, e);
                end
            end
            if (mem_wr) begin
                if (exp_wa.size() == 0) begin
                    check(1'b0, "R5 unexpected write", {8'h0, mem_addr}, 16'h0);
                end else begin
                    logic [7:0] ea;
                    logic [15:0] ed;
                    ea = exp_wa.pop_front();
                    ed = exp_wd.pop_front();
                    check(mem_addr == ea, "R5 store address", {8'h0, mem_addr}, {8'h0, ea});
                    check(mem_wdata == ed, "R5 store data", mem_wdata, ed);
                end
            end
            if (idle_watch && (mem_rd || mem_wr || out_valid)) idle_hits++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // program A: arithmetic, store, branches, input, output
        clear_mem();
        put(0,  ins(4'd5, 40));    // LDA 40
        put(1,  ins(4'd1, 41));    // ADD 41
        put(2,  ins(4'd10, 0));    // OUT
        put(3,  ins(4'd2, 42));    // SUB 42
        put(4,  ins(4'd10, 0));    // OUT
        put(5,  ins(4'd3, 50));    // STA 50
        put(6,  ins(4'd5, 43));    // LDA 43
        put(7,  ins(4'd1, 44));    // ADD 44 (wraps)
        put(8,  ins(4'd10, 0));    // OUT
        put(9,  ins(4'd8, 12));    // BRP 12, negative: falls through
        put(10, ins(4'd10, 0));    // OUT
        put(11, ins(4'd6, 14));    // BRA 14
        put(12, ins(4'd10, 0));    // skipped
        put(13, ins(4'd0, 0));
        put(14, ins(4'd2, 45));    // SUB 45 -> zero
        put(15, ins(4'd7, 18));    // BRZ 18 taken
        put(16, ins(4'd10, 0));    // skipped
        put(17, ins(4'd0, 0));
        put(18, ins(4'd8, 21));    // BRP 21 taken on zero
        put(19, ins(4'd10, 0));    // skipped
        put(20, ins(4'd0, 0));
        put(21, ins(4'd5, 40));    // LDA 40
        put(22, ins(4'd7, 25));    // BRZ 25, nonzero: falls through
        put(23, ins(4'd9, 0));     // INP
        put(24, ins(4'd10, 0));    // OUT
        put(25, ins(4'd3, 51));    // STA 51
        put(26, ins(4'd10, 0));    // OUT
        put(27, ins(4'd0, 0));     // HLT
        put(40, 16'd100);
        put(41, 16'd23);
        put(42, 16'd200);
        put(43, 16'h7FFF);
        put(44, 16'h0001);
        put(45, 16'h8000);

        exp_out.push_back(16'd123);  exp_out_tag.push_back("R4 R5 load then add");
        exp_out.push_back(16'hFFB3); exp_out_tag.push_back("R4 subtract below zero");
        exp_out.push_back(16'h8000); exp_out_tag.push_back("R4 add wraps");
        exp_out.push_back(16'h8000); exp_out_tag.push_back("R8 negative falls through");
        exp_out.push_back(16'h1234); exp_out_tag.push_back("R9 input word loaded");
        exp_out.push_back(16'h1234); exp_out_tag.push_back("R10 output after store");
        exp_wa.push_back(8'd50); exp_wd.push_back(16'hFFB3);
        exp_wa.push_back(8'd51); exp_wd.push_back(16'h1234);

        @(negedge clk);
        check(!mem_rd && !mem_wr, "R1 strobes in reset", {14'b0, mem_rd, mem_wr}, 16'h0);
        check(!in_ready, "R1 in_ready in reset", {15'b0, in_ready}, 16'h0);
        check(!out_valid, "R1 out_valid in reset", {15'b0, out_valid}, 16'h0);
        check(!halted, "R1 halted in reset", {15'b0, halted}, 16'h0);
        check(out_data == 16'h0, "R1 out_data in reset", out_data, 16'h0);

        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(mem_rd && mem_addr == 8'd0, "R1 R2 first fetch at 0", {8'h0, mem_addr}, 16'h0);

        begin
            int n = 0;
            while (!in_ready && n < 2000) begin
                @(negedge clk);
                n++;
            end
            check(in_ready, "R6 R7 R8 branch path reaches input", {15'b0, in_ready}, 16'h1);
        end
        idle_hits = 0;
        idle_watch = 1'b1;
        repeat (8) begin
            @(negedge clk);
            check(in_ready, "R9 ready held while waiting", {15'b0, in_ready}, 16'h1);
        end
        idle_watch = 1'b0;
        check(idle_hits == 0, "R9 no memory access while waiting", idle_hits[15:0], 16'h0);
        in_valid = 1'b1;
        in_data = 16'h1234;
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 16'hDEAD;
        check(!in_ready, "R9 input accepted", {15'b0, in_ready}, 16'h0);

        wait_halt("R11 halt reached");
        idle_hits = 0;
        idle_watch = 1'b1;
        repeat (30) @(negedge clk);
        idle_watch = 1'b0;
        check(idle_hits == 0, "R11 quiet after halt", idle_hits[15:0], 16'h0);
        check(halted, "R11 halted stays high", {15'b0, halted}, 16'h1);
        check(out_data == 16'h1234, "R10 accumulator on out_data", out_data, 16'h1234);
        check(exp_out.size() == 0, "R2 R6 R7 all outputs seen", exp_out.size(), 16'h0);
        check(exp_wa.size() == 0, "R5 all stores seen", exp_wa.size(), 16'h0);
        check(mem[50] == 16'hFFB3, "R5 stored word 50", mem[50], 16'hFFB3);
        check(mem[51] == 16'h1234, "R5 stored word 51", mem[51], 16'h1234);

        // program B: undefined opcode stops the core
        @(negedge clk);
        rst_n = 1'b0;
        clear_mem();
        put(0, ins(4'd5, 40));
        put(1, ins(4'd10, 0));
        put(2, 16'hF000);
        put(3, ins(4'd10, 0));
        put(40, 16'h0ABC);
        exp_out.push_back(16'h0ABC); exp_out_tag.push_back("R3 output before undefined");
        @(negedge clk);
        check(!halted && out_data == 16'h0, "R1 reset clears core", out_data, 16'h0);
        rst_n = 1'b1;
        wait_halt("R3 undefined opcode halts");
        idle_hits = 0;
        idle_watch = 1'b1;
        repeat (30) @(negedge clk);
        idle_watch = 1'b0;
        check(idle_hits == 0, "R3 R11 nothing after undefined", idle_hits[15:0], 16'h0);
        check(exp_out.size() == 0, "R3 output seen", exp_out.size(), 16'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule